// File: doc/BRIEF.md
# Two-Stage-Class ALU Execution Unit

This unit is the arithmetic and logic stage of a small control processor that uses 18-bit instructions and a 16-bit datapath. The core issues one operation per pulse of `issue_i`. Each pulse carries a 4-bit operation code, the destination register value, and a second operand. The second operand is either a register value or an 8-bit immediate, and `imm_form_i` chooses which. The unit returns a result, a write-back strobe for the register file and a set of four condition flags (zero, carry, negative, overflow). It also gives the core a strobe that hands memory-load operations on to the load/store logic.

The two high bits of the operation code set the latency. Codes whose high bits are `00` are the shifts, the multiply and one reserved code. These pass through an extra operand register, so they finish one cycle later than the rest. The unit raises `busy_o` while such an operation is in flight and ignores any issue during that cycle. `done_o` marks the single cycle in which the results of an accepted operation appear.

Top module: `alu_exec_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `done_o`, `busy_o`, `wr_en_o` and `load_req_o` are low, and `result_o` and all four flags are zero.
- R2: An operation accepted at a rising edge whose code has high bits other than `00` gives `done_o`=1 with its results in the cycle that follows that edge. The bitwise codes are `0100` (AND), `0101` (OR), `0110` (XOR) and `1000` (invert of the second operand). Code `1010` (move) copies the second operand. Code `1011` exchanges the two 8-bit halves of the destination operand. Each of these codes writes back (`wr_en_o`=1).
- R3: When `imm_form_i`=1 the second operand is `imm_i` zero-extended to 16 bits. When `imm_form_i`=0 it is `src_reg_i`.
- R4: Code `1100` returns destination plus second operand. Carry is the carry out of bit 15 and overflow is signed overflow. Code `1110` returns destination minus second operand. Carry is set when the destination is below the second operand (unsigned borrow), and overflow is signed overflow. Both codes write back.
- R5: Code `1111` sets all four flags exactly as `1110` would, and `result_o` shows the difference, but `wr_en_o` stays low.
- R6: An operation whose code has high bits `00` raises `busy_o` for exactly the one cycle after it is accepted. Its results and `done_o` appear in the cycle after that.
- R7: Code `0000` shifts the destination right and code `0001` shifts it left, filling with zeros. The shift count is the low 4 bits of the second operand, and higher bits are ignored. Carry takes the last bit shifted out, and a count of zero leaves the value unchanged and clears carry. Overflow is kept.
- R8: Code `0010` returns the low 16 bits of destination times second operand and writes back. Carry and overflow are kept.
- R9: Reserved codes `0011`, `0111` and `1101` give `done_o` with `wr_en_o`=0 and `result_o`=0, and leave all flags unchanged.
- R10: Code `1001` gives `done_o` together with a one-cycle `load_req_o` pulse. It gives `wr_en_o`=0 and `result_o`=0, and leaves the flags unchanged.
- R11: An `issue_i` pulse in a cycle where `busy_o` is high is ignored. It produces no `done_o` of its own and changes no result or flag.
- R12: Every write-back operation sets zero when the result is 0 and sets negative from bit 15. Codes `0100`, `0101`, `0110`, `1000`, `1010` and `1011` keep carry and overflow.
- R13: `wr_en_o` and `load_req_o` are never high in a cycle where `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Request to start an operation this edge |
| imm_form_i | input | 1 | 1: second operand from the immediate field, 0: from the register |
| opcode_i | input | 4 | Operation code |
| dst_val_i | input | 16 | Destination register value (first operand) |
| src_reg_i | input | 16 | Source register value |
| imm_i | input | 8 | Immediate field |
| busy_o | output | 1 | A two-cycle operation is in flight and issue is refused |
| done_o | output | 1 | Results of an accepted operation are present |
| result_o | output | 16 | Operation result |
| wr_en_o | output | 1 | Write result back to the destination register |
| load_req_o | output | 1 | Memory-load code reached completion |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry / borrow / shifted-out bit flag |
| neg_o | output | 1 | Negative flag |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The bench builds the unit with its defaults: a 16-bit datapath, an 8-bit immediate and the multiplier present. These values allow shift counts from 0 to 15 together with a count word whose upper bits are set. They also put the multiply path in the two-cycle class and show the zero-extension of the immediate in the upper byte of the result. Because the flags carry over from one operation to the next, the reference model follows the flag state across the whole run. This exposes a logic operation, a multiply or a reserved code that wrongly changes carry or overflow.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

   typedef enum logic [3:0] {
      OP_SHR   = 4'b0000,
      OP_SHL   = 4'b0001,
      OP_MUL   = 4'b0010,
      OP_RSV_A = 4'b0011,
      OP_AND   = 4'b0100,
      OP_OR    = 4'b0101,
      OP_XOR   = 4'b0110,
      OP_RSV_B = 4'b0111,
      OP_INV   = 4'b1000,
      OP_LOAD  = 4'b1001,
      OP_MOVE  = 4'b1010,
      OP_SWAP  = 4'b1011,
      OP_ADD   = 4'b1100,
      OP_RSV_C = 4'b1101,
      OP_SUB   = 4'b1110,
      OP_CMP   = 4'b1111
   } alu_op_e;

   typedef struct packed {
      logic z;
      logic c;
      logic n;
      logic v;
   } alu_flags_t;

   // the top two code bits select the latency class
   function automatic logic op_is_slow(input alu_op_e op);
      return (op[3:2] == 2'b00);
   endfunction

endpackage

// File: rtl/alu_exec_shifter.sv
module alu_exec_shifter #(
   parameter int DATA_W = 16,
   parameter int SH_W   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] val_i,
   input  logic [SH_W-1:0]   amt_i,
   input  logic              left_i,
   output logic [DATA_W-1:0] res_o,
   output logic              carry_o
);

   // the value sits in a double-width word, so the last bit shifted out
   // lands next to the result and a zero count yields carry 0 by itself
   logic [2*DATA_W-1:0] wide;

   always_comb begin
      if (left_i) begin
         wide    = {{DATA_W{1'b0}}, val_i} << amt_i;
         res_o   = wide[DATA_W-1:0];
         carry_o = wide[DATA_W];
      end else begin
         wide    = {val_i, {DATA_W{1'b0}}} >> amt_i;
         res_o   = wide[2*DATA_W-1:DATA_W];
         carry_o = wide[DATA_W-1];
      end
   end

endmodule

// File: rtl/alu_exec_addsub.sv
module alu_exec_addsub #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              c_o,
   output logic              v_o
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   ext;

   always_comb begin
      b_eff = sub_i ? ~b_i : b_i;
      ext   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
      sum_o = ext[MSB:0];
      // subtract reports a borrow, i.e. the inverted carry out
      c_o   = sub_i ? ~ext[DATA_W] : ext[DATA_W];
      v_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
   end

endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
   import alu_exec_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int IMM_W   = 8,
   parameter bit HAS_MUL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic              imm_form_i,
   input  logic [3:0]        opcode_i,
   input  logic [DATA_W-1:0] dst_val_i,
   input  logic [DATA_W-1:0] src_reg_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] result_o,
   output logic              wr_en_o,
   output logic              load_req_o,
   output logic              zero_o,
   output logic              carry_o,
   output logic              neg_o,
   output logic              ovf_o
);

   localparam int SH_W = $clog2(DATA_W);
   localparam int HALF = DATA_W / 2;
   localparam int MSB  = DATA_W - 1;

   // ---------------- elaboration checks ----------------
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("alu_exec_unit: DATA_W must be a power of two and at least 8");
   end
   if (IMM_W < 1 || IMM_W >= DATA_W) begin : g_bad_imm
      $error("alu_exec_unit: IMM_W must lie in 1..DATA_W-1");
   end

   // ---------------- operand select ----------------
   alu_op_e           op_in;
   logic [DATA_W-1:0] op_b;
   logic              take;
   logic              slow_in;

   assign op_in   = alu_op_e'(opcode_i);
   assign op_b    = imm_form_i ? {{(DATA_W-IMM_W){1'b0}}, imm_i} : src_reg_i;
   assign take    = issue_i && !busy_q;
   assign slow_in = op_is_slow(op_in);

   // ---------------- state ----------------
   logic              busy_q;
   alu_op_e           st_op;
   logic [DATA_W-1:0] st_a;
   logic [DATA_W-1:0] st_b;
   logic              done_q;
   logic [DATA_W-1:0] res_q;
   logic              wr_q;
   logic              ld_q;
   alu_flags_t        flags_q;

   // ---------------- single-cycle path ----------------
   logic [DATA_W-1:0] as_sum;
   logic              as_c;
   logic              as_v;

   alu_exec_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a_i   (dst_val_i),
      .b_i   (op_b),
      .sub_i (op_in == OP_SUB || op_in == OP_CMP),
      .sum_o (as_sum),
      .c_o   (as_c),
      .v_o   (as_v)
   );

   logic [DATA_W-1:0] one_res;
   logic              one_wr;
   logic              one_ld;
   logic              one_zn;
   alu_flags_t        one_fl;

   always_comb begin
      one_res = '0;
      one_wr  = 1'b0;
      one_ld  = 1'b0;
      one_zn  = 1'b0;
      one_fl  = flags_q;
      case (op_in)
         OP_AND:  begin one_res = dst_val_i & op_b; one_wr = 1'b1; one_zn = 1'b1; end
         OP_OR:   begin one_res = dst_val_i | op_b; one_wr = 1'b1; one_zn = 1'b1; end
         OP_XOR:  begin one_res = dst_val_i ^ op_b; one_wr = 1'b1; one_zn = 1'b1; end
         OP_INV:  begin one_res = ~op_b;            one_wr = 1'b1; one_zn = 1'b1; end
         OP_MOVE: begin one_res = op_b;             one_wr = 1'b1; one_zn = 1'b1; end
         OP_SWAP: begin
            one_res = {dst_val_i[HALF-1:0], dst_val_i[MSB:HALF]};
            one_wr  = 1'b1;
            one_zn  = 1'b1;
         end
         OP_ADD, OP_SUB, OP_CMP: begin
            one_res  = as_sum;
            one_wr   = (op_in != OP_CMP);
            one_zn   = 1'b1;
            one_fl.c = as_c;
            one_fl.v = as_v;
         end
         OP_LOAD: one_ld = 1'b1;
         default: ;
      endcase
      if (one_zn) begin
         one_fl.z = (one_res == '0);
         one_fl.n = one_res[MSB];
      end
   end

   // ---------------- two-cycle path (from the staging register) ----------------
   logic [DATA_W-1:0] sh_res;
   logic              sh_c;

   alu_exec_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shifter (
      .val_i   (st_a),
      .amt_i   (st_b[SH_W-1:0]),
      .left_i  (st_op == OP_SHL),
      .res_o   (sh_res),
      .carry_o (sh_c)
   );

   logic [DATA_W-1:0] mul_res;
   logic              mul_ok;

   if (HAS_MUL) begin : g_mul
      logic [2*DATA_W-1:0] prod;
      assign prod    = st_a * st_b;
      assign mul_res = prod[MSB:0];
      assign mul_ok  = 1'b1;
   end else begin : g_no_mul
      assign mul_res = '0;
      assign mul_ok  = 1'b0;
   end

   logic [DATA_W-1:0] two_res;
   logic              two_wr;
   alu_flags_t        two_fl;

   always_comb begin
      two_res = '0;
      two_wr  = 1'b0;
      two_fl  = flags_q;
      case (st_op)
         OP_SHR, OP_SHL: begin
            two_res  = sh_res;
            two_wr   = 1'b1;
            two_fl.c = sh_c;
         end
         OP_MUL: begin
            if (mul_ok) begin
               two_res = mul_res;
               two_wr  = 1'b1;
            end
         end
         default: ;
      endcase
      if (two_wr) begin
         two_fl.z = (two_res == '0);
         two_fl.n = two_res[MSB];
      end
   end

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         st_op   <= OP_SHR;
         st_a    <= '0;
         st_b    <= '0;
         done_q  <= 1'b0;
         res_q   <= '0;
         wr_q    <= 1'b0;
         ld_q    <= 1'b0;
         flags_q <= '0;
      end else begin
         busy_q <= take && slow_in;
         done_q <= (take && !slow_in) || busy_q;
         if (take && slow_in) begin
            st_op <= op_in;
            st_a  <= dst_val_i;
            st_b  <= op_b;
         end
         if (busy_q) begin
            res_q   <= two_res;
            wr_q    <= two_wr;
            ld_q    <= 1'b0;
            flags_q <= two_fl;
         end else if (take && !slow_in) begin
            res_q   <= one_res;
            wr_q    <= one_wr;
            ld_q    <= one_ld;
            flags_q <= one_fl;
         end else begin
            wr_q <= 1'b0;
            ld_q <= 1'b0;
         end
      end
   end

   assign busy_o     = busy_q;
   assign done_o     = done_q;
   assign result_o   = res_q;
   assign wr_en_o    = wr_q;
   assign load_req_o = ld_q;
   assign zero_o     = flags_q.z;
   assign carry_o    = flags_q.c;
   assign neg_o      = flags_q.n;
   assign ovf_o      = flags_q.v;

   // ---------------- assertions ----------------
   AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !busy_o);  // R6

   AST_BUSY_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> done_o);  // R6

   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !busy_o && opcode_i == 4'b1111) |=> (done_o && !wr_en_o));  // R5

   AST_RSVD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !busy_o && (opcode_i == 4'b0111 || opcode_i == 4'b1101))
      |=> $stable({zero_o, carry_o, neg_o, ovf_o}));  // R9

   AST_STROBES_NEED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o || load_req_o) |-> done_o);  // R13

   AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      load_req_o |-> !wr_en_o);  // R10

   AST_BUSY_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && issue_i) |=> !busy_o);  // R11

endmodule

// File: tb/tb_alu_exec_unit.sv
module tb_alu_exec_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic        imm_form_i = 1'b0;
   logic [3:0]  opcode_i = 4'h0;
   logic [15:0] dst_val_i = 16'h0;
   logic [15:0] src_reg_i = 16'h0;
   logic [7:0]  imm_i = 8'h0;
   logic        busy_o, done_o, wr_en_o, load_req_o;
   logic        zero_o, carry_o, neg_o, ovf_o;
   logic [15:0] result_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   alu_exec_unit dut (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .imm_form_i(imm_form_i),
      .opcode_i(opcode_i), .dst_val_i(dst_val_i), .src_reg_i(src_reg_i),
      .imm_i(imm_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
      .wr_en_o(wr_en_o), .load_req_o(load_req_o), .zero_o(zero_o),
      .carry_o(carry_o), .neg_o(neg_o), .ovf_o(ovf_o)
   );

   typedef struct {
      logic [15:0] res;
      logic        wr;
      logic        ld;
      logic [3:0]  fl;   // {z,c,n,v}
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [3:0]  model_fl = 4'b0000;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [3:0] op, input logic [15:0] a,
                                  input logic [15:0] b, input logic [3:0] fin,
                                  input string tag);
      exp_t e;
      logic z, c, n, v, zn;
      logic [16:0] s;
      logic [31:0] p;
      int sh;
      e.res = 16'h0; e.wr = 1'b0; e.ld = 1'b0; e.tag = tag;
      {z, c, n, v} = fin;
      zn = 1'b0;
      sh = int'(b[3:0]);
      case (op)
         4'h0: begin e.res = a >> sh; c = (sh == 0) ? 1'b0 : a[sh-1]; e.wr = 1'b1; zn = 1'b1; end
         4'h1: begin e.res = a << sh; c = (sh == 0) ? 1'b0 : a[16-sh]; e.wr = 1'b1; zn = 1'b1; end
         4'h2: begin p = a * b; e.res = p[15:0]; e.wr = 1'b1; zn = 1'b1; end
         4'h4: begin e.res = a & b; e.wr = 1'b1; zn = 1'b1; end
         4'h5: begin e.res = a | b; e.wr = 1'b1; zn = 1'b1; end
         4'h6: begin e.res = a ^ b; e.wr = 1'b1; zn = 1'b1; end
         4'h8: begin e.res = ~b; e.wr = 1'b1; zn = 1'b1; end
         4'h9: e.ld = 1'b1;
         4'hA: begin e.res = b; e.wr = 1'b1; zn = 1'b1; end
         4'hB: begin e.res = {a[7:0], a[15:8]}; e.wr = 1'b1; zn = 1'b1; end
         4'hC: begin
            s = {1'b0, a} + {1'b0, b};
            e.res = s[15:0]; c = s[16];
            v = (a[15] == b[15]) && (e.res[15] != a[15]);
            e.wr = 1'b1; zn = 1'b1;
         end
         4'hE, 4'hF: begin
            e.res = a - b; c = (a < b);
            v = (a[15] != b[15]) && (e.res[15] != a[15]);
            e.wr = (op == 4'hE); zn = 1'b1;
         end
         default: ;
      endcase
      if (zn) begin z = (e.res == 16'h0); n = e.res[15]; end
      e.fl = {z, c, n, v};
      return e;
   endfunction

   // driver: call just after a falling edge
   task automatic send(input logic [3:0] op, input logic imm, input logic [15:0] a,
                       input logic [15:0] r, input logic [7:0] im, input string tag);
      exp_t e;
      logic [15:0] b;
      b = imm ? {8'h00, im} : r;
      e = model(op, a, b, model_fl, tag);
      model_fl = e.fl;
      sb.push_back(e);
      issue_i = 1'b1; opcode_i = op; imm_form_i = imm;
      dst_val_i = a; src_reg_i = r; imm_i = im;
      @(negedge clk);
      issue_i = 1'b0;
      if (op[3:2] == 2'b00) @(negedge clk);
   endtask

   // monitor
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (done_o) begin
               if (sb.size() == 0) begin
                  check("R11 spurious done", 32'd1, 32'd0);
               end else begin
                  e = sb.pop_front();
                  check({e.tag, " result"}, 32'(result_o), 32'(e.res));
                  check({e.tag, " wr_en"}, 32'(wr_en_o), 32'(e.wr));
                  check({e.tag, " load_req"}, 32'(load_req_o), 32'(e.ld));
                  check({e.tag, " flags zcnv"}, 32'({zero_o, carry_o, neg_o, ovf_o}), 32'(e.fl));
               end
            end else begin
               check("R13 strobes idle", 32'({wr_en_o, load_req_o}), 32'd0);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset outputs", 32'({done_o, busy_o, wr_en_o, load_req_o, zero_o, carry_o, neg_o, ovf_o}), 32'd0);
      check("R1 reset result", 32'(result_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 32'({done_o, busy_o, result_o}), 32'd0);

      send(4'h4, 1'b1, 16'hF0F0, 16'hFFFF, 8'h3C, "R2 R3 and imm");
      send(4'h5, 1'b0, 16'h1200, 16'h0034, 8'hFF, "R2 R3 or reg");
      send(4'h6, 1'b0, 16'hAAAA, 16'hAAAA, 8'h00, "R2 R12 xor zero");
      send(4'h8, 1'b0, 16'h0000, 16'h00FF, 8'h00, "R2 invert");
      send(4'hA, 1'b1, 16'h1234, 16'hFFFF, 8'hFF, "R3 move zero-extend");
      send(4'hB, 1'b0, 16'h12AB, 16'h0000, 8'h00, "R2 byte swap");
      send(4'hC, 1'b1, 16'h7FFF, 16'h0000, 8'h01, "R4 add overflow");
      send(4'hC, 1'b0, 16'hFFFF, 16'h0001, 8'h00, "R4 add carry zero");
      send(4'h4, 1'b0, 16'h8001, 16'h8000, 8'h00, "R12 and keeps c v");
      send(4'hE, 1'b0, 16'h0003, 16'h0005, 8'h00, "R4 sub borrow");
      send(4'hE, 1'b0, 16'h8000, 16'h0001, 8'h00, "R4 sub overflow");
      send(4'hE, 1'b1, 16'h0005, 16'h0000, 8'h05, "R4 sub equal");
      send(4'hF, 1'b0, 16'h0010, 16'h0020, 8'h00, "R5 compare less");
      send(4'hF, 1'b1, 16'h0042, 16'h0000, 8'h42, "R5 compare equal");
      send(4'h0, 1'b1, 16'h8003, 16'h0000, 8'h01, "R6 R7 shr by 1");
      send(4'h0, 1'b1, 16'h8003, 16'h0000, 8'h00, "R7 shr by 0");
      send(4'h0, 1'b0, 16'h8000, 16'h000F, 8'h00, "R7 shr by 15");
      send(4'h1, 1'b0, 16'h1F01, 16'h0004, 8'h00, "R7 shl by 4");
      send(4'h1, 1'b1, 16'h0003, 16'h0000, 8'h13, "R7 shl count low bits");
      send(4'h2, 1'b0, 16'h0123, 16'h0100, 8'h00, "R8 multiply");
      send(4'h2, 1'b1, 16'hFFFF, 16'h0000, 8'hFF, "R8 multiply wrap");
      send(4'h3, 1'b0, 16'h1111, 16'h2222, 8'h00, "R9 reserved 0011");
      send(4'h7, 1'b0, 16'h1111, 16'h2222, 8'h00, "R9 reserved 0111");
      send(4'hD, 1'b0, 16'h0000, 16'h0000, 8'h00, "R9 reserved 1101");
      send(4'h9, 1'b1, 16'h0000, 16'h0000, 8'h10, "R10 load request");

      // R11: issue during busy is refused
      begin
         exp_t e;
         e = model(4'h1, 16'h0001, 16'h0001, model_fl, "R11 shl then refused add");
         model_fl = e.fl;
         sb.push_back(e);
         issue_i = 1'b1; opcode_i = 4'h1; imm_form_i = 1'b0;
         dst_val_i = 16'h0001; src_reg_i = 16'h0001;
         @(negedge clk);
         check("R6 busy after slow issue", 32'(busy_o), 32'd1);
         opcode_i = 4'hC; dst_val_i = 16'hFFFF; src_reg_i = 16'hFFFF;
         @(negedge clk);
         issue_i = 1'b0;
         check("R11 busy dropped", 32'(busy_o), 32'd0);
         @(negedge clk);
         check("R11 no extra done", 32'(done_o), 32'd0);
         check("R11 result unchanged", 32'(result_o), 32'h0002);
      end

      repeat (3) @(negedge clk);
      check("R11 scoreboard drained", 32'(sb.size()), 32'd0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule